// File: doc/BRIEF.md
# USB Host Port Control and Status Register

This block is the per-port control and status register on the host side of a USB controller. Software reaches it through a simple register bus (address, write strobe, write data, registered read data). It sets the levels that tell the port logic to drive bus reset, to stop start-of-frame generation (suspend), to drive resume signalling, and to put the PHY into suspend.

The suspend and resume controls are changed by hardware as well as by software. A detected remote wakeup ends suspend and starts resume signalling on its own. A detected disconnect ends both. The block also reports two live status levels from the port logic, overcurrent and port enabled. Both pass through a synchroniser. Each status level has a sticky change flag that records every transition until software clears it by writing a 1.

Top module: `usb_host_port_ctl`

## Requirements
- R1: Bit 8 (reset request) is read/write and drives `drv_reset_o` from the clock edge of the write. It stays set until software writes it to 0.
- R2: Bit 7 (suspend) drives `sof_stop_o`. `phy_susp_o` is 1 only while bit 7 and the clock-stop bit 12 are both 1.
- R3: Bit 7 is cleared by a `wake_i` pulse, a `disc_i` pulse, or a write carrying 1 in bit 8 or bit 6. This clear takes precedence over a 1 written to bit 7 in the same write.
- R4: Bit 6 (resume) is read/write and drives `drv_resume_o`. A `wake_i` pulse sets it. A `disc_i` pulse clears it, and the clear wins when both pulses arrive in the same cycle.
- R5: Bit 4 reads the synchronised `ovc_i` level and bit 2 reads the synchronised `pen_i` level. Writes to bits 4 and 2 are ignored.
- R6: Bit 5 is set once for each change of the synchronised overcurrent level, rising or falling.
- R7: Bit 3 is set once for each change of the synchronised port-enabled level.
- R8: Bits 5 and 3 are cleared by writing 1 and are unchanged by writing 0. A hardware set in the same cycle as a software clear leaves the flag set.
- R9: Synchronous active-high reset clears every bit and every output. Bits not listed here read as 0, and any address other than `PORT_ADDR` reads as 0.
- R10: `rd_data` is registered: it shows the register state one clock after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| wake_i | input | 1 | Remote-wakeup detected pulse |
| disc_i | input | 1 | Disconnect detected pulse |
| ovc_i | input | 1 | Overcurrent level (asynchronous) |
| pen_i | input | 1 | Port enabled level (asynchronous) |
| drv_reset_o | output | 1 | Drive bus reset |
| sof_stop_o | output | 1 | Stop start-of-frame generation |
| drv_resume_o | output | 1 | Drive resume signalling |
| phy_susp_o | output | 1 | PHY suspend |

## Verification
If the control state is wrong, the control outputs show it one edge after the write or event pulse. Read data shows the same error one cycle later, so a dropped wakeup-driven resume or a suspend that survives a reset write shows up within two cycles. If the synchroniser or edge logic is wrong, the change flags fire twice, never fire, or miss a falling edge, and this shows in read data four cycles after the input level moves. The case where a set and a clear land on the same edge is driven on the exact cycle the edge is detected.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int EN_B     = 2;
  localparam int ENCHG_B  = 3;
  localparam int OC_B     = 4;
  localparam int OCCHG_B  = 5;
  localparam int RES_B    = 6;
  localparam int SUSP_B   = 7;
  localparam int RST_B    = 8;
  localparam int CKSTOP_B = 12;
  localparam int NSTAT    = 2;
  localparam int ST_EN    = 0;
  localparam int ST_OC    = 1;

  typedef struct packed {
    logic ckstop;
    logic rst;
    logic susp;
    logic res;
  } ctl_t;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], lvl_i[g]};
    end
    assign lvl_o[g] = sh[STAGES-1];
    assign chg_o[g] = sh[STAGES] ^ sh[STAGES-1];
  end
endmodule

// File: rtl/hport_flags.sv
module hport_flags #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_q
);
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= set_i | (flag_q & ~clr_i);
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R8
  keep_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/hport_ctl.sv
module hport_ctl
  import hport_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  ctl_t wd_i,
  input  logic wake_i,
  input  logic disc_i,
  output ctl_t ctl_q,
  output logic phy_susp_q
);
  ctl_t nxt;

  always_comb begin
    nxt = ctl_q;
    if (wr_i) nxt = wd_i;
    if (wake_i) nxt.res = 1'b1;
    if (wake_i || disc_i || (wr_i && (wd_i.rst || wd_i.res))) nxt.susp = 1'b0;
    if (disc_i) nxt.res = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      phy_susp_q <= 1'b0;
    end else begin
      ctl_q      <= nxt;
      phy_susp_q <= nxt.susp & nxt.ckstop;
    end
  end

  // R1
  rst_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && wd_i.rst) |=> ctl_q.rst);

  // R3
  wake_susp_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_i || disc_i) |=> !ctl_q.susp);

  // R4
  wake_res_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_i && !disc_i) |=> ctl_q.res);

  // R4
  disc_res_chk: assert property (@(posedge clk) disable iff (rst)
    disc_i |=> !ctl_q.res);
endmodule

// File: rtl/usb_host_port_ctl.sv
module usb_host_port_ctl
  import hport_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 32,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h40,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wake_i,
  input  logic              disc_i,
  input  logic              ovc_i,
  input  logic              pen_i,
  output logic              drv_reset_o,
  output logic              sof_stop_o,
  output logic              drv_resume_o,
  output logic              phy_susp_o
);
  logic             sel_wr;
  ctl_t             wd_ctl;
  ctl_t             ctl_q;
  logic             phy_susp_q;
  logic [NSTAT-1:0] st_raw, st_lvl, st_chg, st_clr, st_flag;
  logic [DATA_W-1:0] image;
  logic             unused_wbits;

  assign sel_wr = wr_en && (addr == PORT_ADDR);

  assign wd_ctl.ckstop = wr_data[CKSTOP_B];
  assign wd_ctl.rst    = wr_data[RST_B];
  assign wd_ctl.susp   = wr_data[SUSP_B];
  assign wd_ctl.res    = wr_data[RES_B];

  assign unused_wbits = ^{wr_data[DATA_W-1:CKSTOP_B+1], wr_data[CKSTOP_B-1:RST_B+1],
                          wr_data[OC_B], wr_data[EN_B], wr_data[1:0]};

  hport_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (sel_wr),
    .wd_i       (wd_ctl),
    .wake_i     (wake_i),
    .disc_i     (disc_i),
    .ctl_q      (ctl_q),
    .phy_susp_q (phy_susp_q)
  );

  assign st_raw[ST_EN] = pen_i;
  assign st_raw[ST_OC] = ovc_i;

  hport_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (st_raw),
    .lvl_o (st_lvl),
    .chg_o (st_chg)
  );

  assign st_clr[ST_EN] = sel_wr & wr_data[ENCHG_B];
  assign st_clr[ST_OC] = sel_wr & wr_data[OCCHG_B];

  hport_flags #(.W(NSTAT)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (st_chg),
    .clr_i  (st_clr),
    .flag_q (st_flag)
  );

  always_comb begin
    image           = '0;
    image[CKSTOP_B] = ctl_q.ckstop;
    image[RST_B]    = ctl_q.rst;
    image[SUSP_B]   = ctl_q.susp;
    image[RES_B]    = ctl_q.res;
    image[OCCHG_B]  = st_flag[ST_OC];
    image[OC_B]     = st_lvl[ST_OC];
    image[ENCHG_B]  = st_flag[ST_EN];
    image[EN_B]     = st_lvl[ST_EN];
  end

  always_ff @(posedge clk) begin
    if (rst)                    rd_data <= '0;
    else if (addr == PORT_ADDR) rd_data <= image;
    else                        rd_data <= '0;
  end

  assign drv_reset_o  = ctl_q.rst;
  assign sof_stop_o   = ctl_q.susp;
  assign drv_resume_o = ctl_q.res;
  assign phy_susp_o   = phy_susp_q;

  // R2
  phy_needs_susp_chk: assert property (@(posedge clk) disable iff (rst)
    phy_susp_o |-> sof_stop_o);

  // R9
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr != PORT_ADDR) |=> (rd_data == '0));
endmodule

// File: tb/sim_usb_host_port_ctl.sv
`timescale 1ns/1ps
module sim_usb_host_port_ctl;
  localparam logic [7:0] PA = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = PA;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wake_i = 1'b0, disc_i = 1'b0, ovc_i = 1'b0, pen_i = 1'b0;
  logic        drv_reset_o, sof_stop_o, drv_resume_o, phy_susp_o;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  usb_host_port_ctl #(.PORT_ADDR(PA)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wake_i(wake_i), .disc_i(disc_i), .ovc_i(ovc_i),
    .pen_i(pen_i), .drv_reset_o(drv_reset_o), .sof_stop_o(sof_stop_o),
    .drv_resume_o(drv_resume_o), .phy_susp_o(phy_susp_o)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] wd;
    logic        wake;
    logic        disc;
    logic        ovc;
    logic        en;
    logic [15:0] exp_rd;
    logic [3:0]  exp_out; // {reset, sof_stop, resume, phy_susp}
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0080, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0080, 4'b0100}, // R2 suspend
    '{1'b1, 16'h1080, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1080, 4'b0101}, // R2 clock stop
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1040, 4'b0010}, // R3 R4 wakeup
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1000, 4'b0000}, // R4 disconnect
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1030, 4'b0000}, // R5 R6 ovc rise
    '{1'b1, 16'h0020, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0010, 4'b0000}, // R8 clear
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h001C, 4'b0000}, // R7 en rise
    '{1'b1, 16'h0088, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0094, 4'b0100}, // R2 R8
    '{1'b1, 16'h0180, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0114, 4'b1000}, // R1 R3
    '{1'b1, 16'h00C0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0054, 4'b0010}, // R3 R4
    '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0014, 4'b0000}, // R5 ro ignored
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0028, 4'b0000}  // R6 R7 falls
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {16'h0, d};
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [3:0] outs();
    return {drv_reset_o, sof_stop_o, drv_resume_o, phy_susp_o};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset rd", rd_data, 32'h0);
    chk("R9 reset outputs", {28'h0, outs()}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VECS[i].wr; wr_data = {16'h0, VECS[i].wd};
      wake_i = VECS[i].wake; disc_i = VECS[i].disc;
      ovc_i = VECS[i].ovc; pen_i = VECS[i].en;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wake_i = 1'b0; disc_i = 1'b0;
      settle();
      chk($sformatf("R1-table vector %0d rd", i), rd_data, {16'h0, VECS[i].exp_rd});
      chk($sformatf("R2-table vector %0d outputs", i), {28'h0, outs()}, {28'h0, VECS[i].exp_out});
    end

    // R8 clear both flags
    wr(16'h0028);
    settle();
    chk("R8 w1c both", rd_data, 32'h0);

    // R8 set and clear on the same edge: set wins
    @(negedge clk); ovc_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h20;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    settle();
    chk("R8 set beats clear", rd_data, 32'h30);

    // R8 writing 0 leaves flag
    wr(16'h0000);
    settle();
    chk("R8 write zero", rd_data, 32'h30);

    // R6 level held: no second set after clear
    wr(16'h0020);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R6 once per change", rd_data, 32'h10);
    wr(16'h0020); // no-op clear, flag already 0

    // R4 wake and disconnect together
    @(negedge clk); ovc_i = 1'b0;
    settle();
    wr(16'h0028);
    wr(16'h0080);
    @(negedge clk); wake_i = 1'b1; disc_i = 1'b1;
    @(posedge clk);
    @(negedge clk); wake_i = 1'b0; disc_i = 1'b0;
    settle();
    chk("R4 disc wins rd", rd_data, 32'h0);
    chk("R3 wake+disc outputs", {28'h0, outs()}, 32'h0);

    // R9 other address
    @(negedge clk); addr = PA + 8'd1;
    settle();
    chk("R9 other addr", rd_data, 32'h0);
    @(negedge clk); addr = PA;
    settle();

    // R10 read latency, R1 output on write edge
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h100;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R1 drv_reset on edge", {31'h0, drv_reset_o}, 32'h1);
    chk("R10 rd still old", rd_data, 32'h0);
    @(negedge clk);
    chk("R10 rd one later", rd_data, 32'h100);

    // R9 reset mid-run
    wr(16'h1080);
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 reset rd mid", rd_data, 32'h0);
    chk("R9 reset outs mid", {28'h0, outs()}, 32'h0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule